// File: doc/BRIEF.md
# Serial Audio Link Left-Channel Tap

This block listens to the serial data line of an audio codec link, in parallel with the controller that owns the link, and drives nothing onto it. It follows the frame structure with a small state machine. From each frame it recovers the 16-bit left-channel capture sample and places it in a small output FIFO. An analysis engine, such as a streaming 1024-point FFT, can then take an unbroken stream of left-channel PCM words without any bus transfers.

The link signals come from the codec's clock domain. The block samples the bit clock, the frame sync and the serial data with the system clock, through synchronizer stages. A falling edge of the bit clock becomes a one-cycle enable, and all framing logic runs on that enable. Each frame is 256 bits long. It starts with a 16-bit tag, which is followed by twelve 20-bit slots. Bits travel MSB first. The sample is the upper 16 bits of slot 3, and it is kept only when the tag marks slot 3 as valid.

Top module: `ac97_left_tap`

## Requirements
- R1: While reset is active and right after reset, `pcm_valid` and `overflow` are low.
- R2: A frame begins with the first bit sampled on a falling bit-clock edge at which the sync input is high, after it was low at the previous falling edge. That bit has frame index 0. A frame then runs for 256 bit indices: a 16-bit tag at indices 0..15, then twelve 20-bit slots.
- R3: The delivered word is made of frame bits 56..71, taken MSB first: bit 56 becomes `pcm_data[15]` and bit 71 becomes `pcm_data[0]`. These are the upper 16 bits of slot 3. The content of every other slot has no effect on the word.
- R4: A word is delivered only when frame bit 3 (the slot-3 valid flag in the tag) is 1. When that bit is 0, the frame yields nothing, whatever the other tag bits are.
- R5: After the 256 bits of a frame, the block waits for the next sync rise. Bits that arrive with no sync rise produce no word.
- R6: A sync rise that appears inside a running frame restarts framing at index 0. The partial frame yields nothing, unless it already passed index 71.
- R7: The FIFO delivers words in arrival order and holds up to 16 of them. A word moves only in a cycle where `pcm_valid` and `pcm_ready` are both high. While `pcm_valid` is high and `pcm_ready` is low, `pcm_data` holds steady.
- R8: A word that arrives while 16 words are held is discarded, and `overflow` goes high. `overflow` stays high until reset. The 16 words already held are delivered intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ac_bit_clk | input | 1 | Link bit clock (tapped) |
| ac_sync | input | 1 | Link frame sync (tapped) |
| ac_sdata_in | input | 1 | Codec-to-controller serial data (tapped) |
| pcm_data | output | 16 | Left-channel PCM word at the FIFO head |
| pcm_valid | output | 1 | FIFO holds at least one word |
| pcm_ready | input | 1 | Consumer accepts the head word |
| overflow | output | 1 | Sticky flag: a word was discarded because the FIFO was full |

## Verification
The bench uses the default parameters: two synchronizer stages, a 16-entry FIFO, 16-bit samples and the 16+12×20 frame. It runs the bit clock at eight system clocks per bit. With a 16-entry FIFO, the overflow boundary comes after only seventeen frames. That makes it possible to check, in one run, that exactly sixteen words fit and that the seventeenth is discarded. The slow bit clock leaves several system cycles between link edges. This lets the bench check that a word stays steady under back-pressure, and that no word appears for frames with the tag flag cleared, for sync-less bit trains and for frames cut short by a resync.

// File: rtl/ac97tap_pkg.sv
package ac97tap_pkg;
  typedef enum logic [0:0] {
    FR_HUNT  = 1'b0,
    FR_FRAME = 1'b1
  } frame_state_e;
endpackage

// File: rtl/ac97tap_rst_sync.sv
module ac97tap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ac97tap_link_sampler.sv
module ac97tap_link_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_clk_in,
  input  logic sync_in,
  input  logic sdata_in,
  output logic bit_fall,
  output logic sync_s,
  output logic sdata_s
);
  logic [STAGES-1:0] bclk_pipe_q;
  logic [STAGES-1:0] sync_pipe_q;
  logic [STAGES-1:0] data_pipe_q;
  logic              bclk_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_pipe_q <= '0;
      sync_pipe_q <= '0;
      data_pipe_q <= '0;
      bclk_last_q <= 1'b0;
    end else begin
      bclk_pipe_q <= {bclk_pipe_q[STAGES-2:0], bit_clk_in};
      sync_pipe_q <= {sync_pipe_q[STAGES-2:0], sync_in};
      data_pipe_q <= {data_pipe_q[STAGES-2:0], sdata_in};
      bclk_last_q <= bclk_pipe_q[STAGES-1];
    end
  end

  assign bit_fall = bclk_last_q & ~bclk_pipe_q[STAGES-1];
  assign sync_s   = sync_pipe_q[STAGES-1];
  assign sdata_s  = data_pipe_q[STAGES-1];
endmodule

// File: rtl/ac97tap_framer.sv
module ac97tap_framer
  import ac97tap_pkg::*;
#(
  parameter int TAG_W        = 16,
  parameter int SLOT_W       = 20,
  parameter int NUM_SLOTS    = 12,
  parameter int CAPTURE_SLOT = 3,
  parameter int SAMPLE_W     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_fall,
  input  logic                sync_s,
  input  logic                sdata_s,
  output logic                push,
  output logic [SAMPLE_W-1:0] push_data
);
  localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int CAP_FIRST  = TAG_W + (CAPTURE_SLOT - 1) * SLOT_W;
  localparam int CAP_LAST   = CAP_FIRST + SAMPLE_W - 1;
  localparam logic [IDX_W-1:0] IDX_FLAG  = IDX_W'(CAPTURE_SLOT);
  localparam logic [IDX_W-1:0] IDX_FIRST = IDX_W'(CAP_FIRST);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(CAP_LAST);
  localparam logic [IDX_W-1:0] IDX_END   = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_ONE   = IDX_W'(1);

  frame_state_e        state_q, state_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic                sync_last_q, sync_last_d;
  logic                flag_q, flag_d;
  logic [SAMPLE_W-1:0] shift_q, shift_d;
  logic                sync_rise;

  assign sync_rise = sync_s & ~sync_last_q;

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    sync_last_d = sync_last_q;
    flag_d      = flag_q;
    shift_d     = shift_q;
    push        = 1'b0;
    push_data   = {shift_q[SAMPLE_W-2:0], sdata_s};
    if (bit_fall) begin
      sync_last_d = sync_s;
      if (sync_rise) begin
        state_d = FR_FRAME;
        idx_d   = IDX_ONE;
        flag_d  = 1'b0;
      end else if (state_q == FR_FRAME) begin
        if (idx_q == IDX_FLAG) flag_d = sdata_s;
        if (idx_q >= IDX_FIRST && idx_q <= IDX_LAST) shift_d = push_data;
        if (idx_q == IDX_LAST) push = flag_q;
        if (idx_q == IDX_END) begin
          state_d = FR_HUNT;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + IDX_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= FR_HUNT;
      idx_q       <= '0;
      sync_last_q <= 1'b0;
      flag_q      <= 1'b0;
      shift_q     <= '0;
    end else if (bit_fall) begin
      state_q     <= state_d;
      idx_q       <= idx_d;
      sync_last_q <= sync_last_d;
      flag_q      <= flag_d;
      shift_q     <= shift_d;
    end
  end

  // R2: index advances by one per link bit inside a frame
  assert_index_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_fall && state_q == FR_FRAME && !sync_rise && idx_q != IDX_END
      |=> idx_q == $past(idx_q) + IDX_ONE);

  // R2: index frozen between link bits
  assert_index_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_fall |=> $stable(idx_q) && $stable(state_q));

  // R5: hunting state parks the index at zero
  assert_hunt_parked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == FR_HUNT |-> idx_q == '0);

  // R6: a sync rise always restarts framing
  assert_resync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_fall && sync_s && !sync_last_q |=> state_q == FR_FRAME && idx_q == IDX_ONE);
endmodule

// File: rtl/ac97tap_fifo.sv
module ac97tap_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              overflow
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] DEPTH_C = (PTR_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W:0]    wr_ptr_q, wr_ptr_d;
  logic [PTR_W:0]    rd_ptr_q, rd_ptr_d;
  logic              ovf_q, ovf_d;
  logic [PTR_W:0]    level;
  logic              full, empty, wr_en, rd_en;

  assign level = wr_ptr_q - rd_ptr_q;
  assign full  = (level == DEPTH_C);
  assign empty = (level == '0);
  assign wr_en = wr_req & ~full;
  assign rd_en = rd_valid & rd_ready;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    ovf_d    = ovf_q;
    if (wr_en)          wr_ptr_d = wr_ptr_q + 1'b1;
    if (rd_en)          rd_ptr_d = rd_ptr_q + 1'b1;
    if (wr_req && full) ovf_d    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      ovf_q    <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_ptr_q[PTR_W-1:0]] <= wr_data;
  end

  assign rd_data  = mem_q[rd_ptr_q[PTR_W-1:0]];
  assign rd_valid = ~empty;
  assign overflow = ovf_q;

  // R7: occupancy bounded by depth
  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH_C);

  // R7: head word steady under back-pressure
  assert_hold_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R8: overflow flag is sticky
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R8: overflow only raised by a write into a full buffer
  assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(wr_req && full));
endmodule

// File: rtl/ac97_left_tap.sv
module ac97_left_tap #(
  parameter int SYNC_STAGES  = 2,
  parameter int TAG_W        = 16,
  parameter int SLOT_W       = 20,
  parameter int NUM_SLOTS    = 12,
  parameter int CAPTURE_SLOT = 3,
  parameter int SAMPLE_W     = 16,
  parameter int FIFO_DEPTH   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ac_bit_clk,
  input  logic                ac_sync,
  input  logic                ac_sdata_in,
  output logic [SAMPLE_W-1:0] pcm_data,
  output logic                pcm_valid,
  input  logic                pcm_ready,
  output logic                overflow
);
  logic                rst_n_int;
  logic                bit_fall, sync_s, sdata_s;
  logic                push;
  logic [SAMPLE_W-1:0] push_data;

  ac97tap_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  ac97tap_link_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n_int),
    .bit_clk_in(ac_bit_clk), .sync_in(ac_sync), .sdata_in(ac_sdata_in),
    .bit_fall(bit_fall), .sync_s(sync_s), .sdata_s(sdata_s)
  );

  ac97tap_framer #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
    .CAPTURE_SLOT(CAPTURE_SLOT), .SAMPLE_W(SAMPLE_W)
  ) u_framer (
    .clk(clk), .rst_n(rst_n_int),
    .bit_fall(bit_fall), .sync_s(sync_s), .sdata_s(sdata_s),
    .push(push), .push_data(push_data)
  );

  ac97tap_fifo #(.DATA_W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n_int),
    .wr_req(push), .wr_data(push_data),
    .rd_data(pcm_data), .rd_valid(pcm_valid), .rd_ready(pcm_ready),
    .overflow(overflow)
  );

  // R1: outputs quiet while held in reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n_int |-> !pcm_valid && !overflow);
endmodule

// File: tb/ac97_left_tap_tb_top.sv
module ac97_left_tap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ac_bit_clk = 1'b0;
  logic        ac_sync = 1'b0;
  logic        ac_sdata_in = 1'b0;
  logic [15:0] pcm_data;
  logic        pcm_valid;
  logic        pcm_ready = 1'b0;
  logic        overflow;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  ac97_left_tap dut_i (
    .clk(clk), .rst_n(rst_n),
    .ac_bit_clk(ac_bit_clk), .ac_sync(ac_sync), .ac_sdata_in(ac_sdata_in),
    .pcm_data(pcm_data), .pcm_valid(pcm_valid), .pcm_ready(pcm_ready),
    .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send_bit(input logic s, input logic d);
    @(negedge clk);
    ac_bit_clk  = 1'b1;
    ac_sync     = s;
    ac_sdata_in = d;
    repeat (4) @(negedge clk);
    ac_bit_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic filler(input int b);
    return logic'((b ^ (b >> 2) ^ (b >> 5)) & 1);
  endfunction

  // frame: index 0..15 tag (bit 3 = slot-3 flag), bits 56..71 = word MSB first
  task automatic send_frame(input logic [15:0] word, input logic flag,
                            input logic use_sync, input int nbits);
    for (int b = 0; b < nbits; b++) begin
      logic d;
      if (b == 3)                 d = flag;
      else if (b < 16)            d = 1'b1;
      else if (b >= 56 && b < 72) d = word[71-b];
      else                        d = filler(b);
      send_bit(use_sync && (b < 16), d);
    end
  endtask

  task automatic drain(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [15:0] e;
      int w = 0;
      while (!pcm_valid && w < 50) begin @(negedge clk); w++; end
      e = exp_q.pop_front();
      chk(pcm_valid === 1'b1, req, 32'(pcm_valid), 32'h1);
      chk(pcm_data === e, req, 32'(pcm_data), 32'(e));
      pcm_ready = 1'b1;
      @(negedge clk);
      pcm_ready = 1'b0;
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(pcm_valid === 1'b0, "R1 valid in reset", 32'(pcm_valid), 0);
    chk(overflow === 1'b0, "R1 overflow in reset", 32'(overflow), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(pcm_valid === 1'b0, "R1 valid after reset", 32'(pcm_valid), 0);
    chk(overflow === 1'b0, "R1 overflow after reset", 32'(overflow), 0);
  endtask

  task automatic test_basic();
    logic [15:0] words [3] = '{16'hA5C3, 16'h0001, 16'h8000};
    for (int i = 0; i < 3; i++) begin
      send_frame(words[i], 1'b1, 1'b1, 256);
      exp_q.push_back(words[i]);
    end
    drain(3, "R2 R3 word order and bit placement");
    chk(pcm_valid === 1'b0, "R3 no extra word", 32'(pcm_valid), 0);
  endtask

  task automatic test_flag_clear();
    send_frame(16'h1234, 1'b0, 1'b1, 256);
    repeat (20) @(negedge clk);
    chk(pcm_valid === 1'b0, "R4 flag clear yields nothing", 32'(pcm_valid), 0);
  endtask

  task automatic test_no_sync();
    send_frame(16'h5A5A, 1'b1, 1'b0, 256);
    repeat (20) @(negedge clk);
    chk(pcm_valid === 1'b0, "R5 no sync rise yields nothing", 32'(pcm_valid), 0);
    send_frame(16'h3C3C, 1'b1, 1'b1, 256);
    exp_q.push_back(16'h3C3C);
    drain(1, "R5 framing resumes on next sync");
  endtask

  task automatic test_resync();
    send_frame(16'hDEAD, 1'b1, 1'b1, 60);
    send_frame(16'hBEEF, 1'b1, 1'b1, 256);
    exp_q.push_back(16'hBEEF);
    drain(1, "R6 resync restarts frame");
    chk(pcm_valid === 1'b0, "R6 cut frame yields nothing", 32'(pcm_valid), 0);
  endtask

  task automatic test_hold();
    logic [15:0] first;
    send_frame(16'h1111, 1'b1, 1'b1, 256);
    send_frame(16'h2222, 1'b1, 1'b1, 256);
    first = pcm_data;
    repeat (20) @(negedge clk);
    chk(pcm_valid === 1'b1 && pcm_data === first, "R7 head steady without ready",
        32'(pcm_data), 32'(first));
    chk(first === 16'h1111, "R7 head is oldest", 32'(first), 32'h1111);
    exp_q.push_back(16'h1111);
    exp_q.push_back(16'h2222);
    drain(2, "R7 handshake order");
  endtask

  task automatic test_overflow();
    for (int i = 0; i < 16; i++) begin
      logic [15:0] w = 16'(16'h0F00 + i * 16'h0111);
      send_frame(w, 1'b1, 1'b1, 256);
      exp_q.push_back(w);
    end
    chk(overflow === 1'b0, "R7 sixteen words fit", 32'(overflow), 0);
    send_frame(16'hFFFF, 1'b1, 1'b1, 256);
    chk(overflow === 1'b1, "R8 overflow raised", 32'(overflow), 1);
    drain(16, "R8 held words intact");
    repeat (10) @(negedge clk);
    chk(pcm_valid === 1'b0, "R8 newest word dropped", 32'(pcm_valid), 0);
    chk(overflow === 1'b1, "R8 overflow sticky", 32'(overflow), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_basic();
    test_flag_clear();
    test_no_sync();
    test_resync();
    test_hold();
    test_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule